// File: doc/BRIEF.md
# Coprocessor Interrupt Raise Path

This block is the interrupt-request path of a display-list coprocessor that shares a video chip's interrupt mask and interrupt status registers. The instruction executor presents each fetched opcode byte with a valid strobe. When the byte is the raise opcode, the block sets a dedicated status bit and the summary bit, but only if the matching mask bit is set. It then pulls the CPU interrupt line low.

The host bus writes the mask register and acknowledges pending requests by writing ones to the status register. This is the same write-one-to-clear scheme that the video chip's own interrupt sources use. Those other sources reach the block only as generic set pulses on status bits 3..0. The interrupt line is active low and open drain. It is modelled as a level that stays low until every enabled pending bit has been acknowledged.

Top module: `cop_irq_top`

## Requirements
- R1: A raise opcode (byte 0xA2 with op_valid_i high) while mask bit 4 is 0 changes neither status_o nor irq_n_o.
- R2: A raise opcode while mask bit 4 is 1 sets status bits 4 and 7 on the next clock edge.
- R3: A host write with host_sel_i = 1 (status register) and data bit n = 1 clears status bit n, for n in 0..4.
- R4: Status bit 7 equals the OR of status bits 4..0 ANDed with mask bits 4..0. It clears by itself once no enabled bit remains set, and it follows mask changes.
- R5: irq_n_o is 0 exactly while status bit 7 is 1, and 1 otherwise.
- R6: Status write data bits that are 0 leave the corresponding status bits unchanged. Bits 7..5 of a status write have no effect.
- R7: When an enabled raise and an acknowledge of bit 4 fall in the same cycle, status bit 4 is set afterwards.
- R8: After reset the mask reads 0x00, the status reads 0x00 and irq_n_o is 1.
- R9: A pulse on src_set_i[n] sets status bit n (n in 0..3) whatever the mask. A source pulse in the same cycle as its acknowledge leaves the bit set.
- R10: A host write with host_sel_i = 0 loads all 8 bits of the mask register, which reads back on mask_o. Status bits 6 and 5 always read 0.
- R11: With op_valid_i low, or with any opcode byte other than 0xA2, nothing is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Executor opcode strobe, one cycle per instruction |
| op_i | input | 8 | Executor opcode byte |
| src_set_i | input | 4 | Set pulses from the video chip's own sources, status bits 3..0 |
| host_we_i | input | 1 | Host register write strobe |
| host_sel_i | input | 1 | 0 selects the mask register, 1 selects the status register |
| host_wdata_i | input | 8 | Host write data |
| mask_o | output | 8 | Mask register contents |
| status_o | output | 8 | Status register: bit 7 summary, bits 4..0 pending |
| irq_n_o | output | 1 | CPU interrupt request, active low |

## Verification
Any corrupted pending bit or mask bit is visible one clock edge later on status_o. Because the summary and the interrupt line are derived without a further register, an enabled corruption also shows on irq_n_o within that same cycle. A raise lost to the mask check or to an acknowledge collision shows as status bit 4 reading 0 one edge after the opcode. A summary bit that does not follow the mask shows on the first cycle after a mask write. The random phase compares both registers and the line after every edge, so a divergence is reported on the cycle it appears.

// File: rtl/cop_irq_pkg.sv
package cop_irq_pkg;
  parameter int unsigned REG_W   = 8;
  parameter int unsigned SRC_N   = 4;
  parameter int unsigned COP_BIT = 4;
  parameter int unsigned SUM_BIT = 7;
  parameter logic [REG_W-1:0] RAISE_OP = 8'hA2;

  typedef enum logic {
    SEL_MASK   = 1'b0,
    SEL_STATUS = 1'b1
  } host_sel_e;
endpackage

// File: rtl/cop_irq_decode.sv
module cop_irq_decode
  import cop_irq_pkg::*;
#(
  parameter int unsigned OP_W = REG_W,
  parameter logic [OP_W-1:0] OPCODE = RAISE_OP
) (
  input  logic            op_valid_i,
  input  logic [OP_W-1:0] op_i,
  input  logic            en_i,
  output logic            raise_o
);
  always_comb raise_o = op_valid_i && (op_i == OPCODE) && en_i;
endmodule

// File: rtl/cop_irq_mask_reg.sv
module cop_irq_mask_reg
  import cop_irq_pkg::*;
#(
  parameter int unsigned W = REG_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= wdata_i;
  end
endmodule

// File: rtl/cop_irq_status_reg.sv
module cop_irq_status_reg
  import cop_irq_pkg::*;
#(
  parameter int unsigned W    = REG_W,
  parameter int unsigned NSRC = SRC_N,
  parameter int unsigned CBIT = COP_BIT,
  parameter int unsigned SBIT = SUM_BIT
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] src_set_i,
  input  logic            raise_i,
  input  logic            ack_we_i,
  input  logic [W-1:0]    ack_data_i,
  input  logic [W-1:0]    mask_i,
  output logic [W-1:0]    status_o,
  output logic            sum_o
);
  localparam int unsigned PEND_N = CBIT + 1;

  logic [PEND_N-1:0] pend_q;
  logic [PEND_N-1:0] set_v;
  logic [PEND_N-1:0] clr_v;

  always_comb begin
    set_v = '0;
    set_v[NSRC-1:0] = src_set_i;
    set_v[CBIT] = raise_i;
    clr_v = ack_we_i ? ack_data_i[PEND_N-1:0] : '0;
  end

  // set has priority over acknowledge on every bit
  for (genvar i = 0; i < PEND_N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       pend_q[i] <= 1'b0;
      else if (set_v[i]) pend_q[i] <= 1'b1;
      else if (clr_v[i]) pend_q[i] <= 1'b0;
    end
  end

  always_comb begin
    sum_o = |(pend_q & mask_i[PEND_N-1:0]);
    status_o = '0;
    status_o[PEND_N-1:0] = pend_q;
    status_o[SBIT] = sum_o;
  end
endmodule

// File: rtl/cop_irq_line.sv
module cop_irq_line (
  input  logic req_i,
  output logic irq_n_o
);
  // open-drain: pull low while requesting, otherwise released
  always_comb irq_n_o = !req_i;
endmodule

// File: rtl/cop_irq_top.sv
module cop_irq_top
  import cop_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             op_valid_i,
  input  logic [REG_W-1:0] op_i,
  input  logic [SRC_N-1:0] src_set_i,
  input  logic             host_we_i,
  input  logic             host_sel_i,
  input  logic [REG_W-1:0] host_wdata_i,
  output logic [REG_W-1:0] mask_o,
  output logic [REG_W-1:0] status_o,
  output logic             irq_n_o
);
  logic raise;
  logic sum;
  logic mask_we;
  logic stat_we;

  always_comb begin
    mask_we = host_we_i && (host_sel_e'(host_sel_i) == SEL_MASK);
    stat_we = host_we_i && (host_sel_e'(host_sel_i) == SEL_STATUS);
  end

  cop_irq_decode u_dec (
    .op_valid_i(op_valid_i),
    .op_i      (op_i),
    .en_i      (mask_o[COP_BIT]),
    .raise_o   (raise)
  );

  cop_irq_mask_reg u_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (mask_we),
    .wdata_i(host_wdata_i),
    .q_o    (mask_o)
  );

  cop_irq_status_reg u_stat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .src_set_i (src_set_i),
    .raise_i   (raise),
    .ack_we_i  (stat_we),
    .ack_data_i(host_wdata_i),
    .mask_i    (mask_o),
    .status_o  (status_o),
    .sum_o     (sum)
  );

  cop_irq_line u_line (
    .req_i  (sum),
    .irq_n_o(irq_n_o)
  );
endmodule

// File: rtl/cop_irq_checker.sv
module cop_irq_checker
  import cop_irq_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             op_valid_i,
  input logic [REG_W-1:0] op_i,
  input logic [SRC_N-1:0] src_set_i,
  input logic             host_we_i,
  input logic             host_sel_i,
  input logic [REG_W-1:0] host_wdata_i,
  input logic [REG_W-1:0] mask_o,
  input logic [REG_W-1:0] status_o,
  input logic             irq_n_o
);
  logic is_raise;
  logic ack4;
  always_comb begin
    is_raise = op_valid_i && (op_i == RAISE_OP);
    ack4 = host_we_i && host_sel_i && host_wdata_i[COP_BIT];
  end

  a_r1_masked_raise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_raise && !mask_o[COP_BIT] |=> !$rose(status_o[COP_BIT]));

  a_r2_raise_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_raise && mask_o[COP_BIT] && !(host_we_i && !host_sel_i)
    |=> status_o[COP_BIT] && status_o[SUM_BIT]);

  a_r3_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack4 && !is_raise |=> !status_o[COP_BIT]);

  a_r5_line_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_n_o == !status_o[SUM_BIT]);

  a_r6_zero_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_we_i && host_sel_i && host_wdata_i == '0 && !is_raise && src_set_i == '0
    |=> $stable(status_o[COP_BIT:0]));

  a_r7_raise_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_raise && mask_o[COP_BIT] && ack4 |=> status_o[COP_BIT]);

  a_r10_spare_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[SUM_BIT-1:COP_BIT+1] == '0);
endmodule

bind cop_irq_top cop_irq_checker u_chk (.*);

// File: tb/sim_cop_irq_top.sv
module sim_cop_irq_top;
  localparam int CLK_T = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       op_valid_i = 1'b0;
  logic [7:0] op_i = 8'h00;
  logic [3:0] src_set_i = 4'h0;
  logic       host_we_i = 1'b0;
  logic       host_sel_i = 1'b0;
  logic [7:0] host_wdata_i = 8'h00;
  logic [7:0] mask_o;
  logic [7:0] status_o;
  logic       irq_n_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] m_mask = 8'h00;
  logic [4:0] m_pend = 5'h00;

  always #(CLK_T/2) clk_i = ~clk_i;

  cop_irq_top u0 (.*);

  function automatic logic [7:0] exp_status(logic [4:0] p, logic [7:0] m);
    return {|(p & m[4:0]), 2'b00, p};
  endfunction

  task automatic check(string tag);
    logic [7:0] es;
    es = exp_status(m_pend, m_mask);
    n_chk++;
    if (mask_o !== m_mask || status_o !== es || irq_n_o !== !es[7]) begin
      n_bad++;
      $display("FAIL %s: mask=%h status=%h irq_n=%b expected mask=%h status=%h irq_n=%b",
               tag, mask_o, status_o, irq_n_o, m_mask, es, !es[7]);
    end
  endtask

  // drive at negedge, advance model, sample at next negedge
  task automatic step(logic v, logic [7:0] op, logic [3:0] src, logic we, logic sel,
                      logic [7:0] wd, string tag);
    logic raise;
    logic [4:0] set_v, clr_v;
    op_valid_i = v; op_i = op; src_set_i = src;
    host_we_i = we; host_sel_i = sel; host_wdata_i = wd;
    raise = v && op == 8'hA2 && m_mask[4];
    set_v = {raise, src};
    clr_v = (we && sel) ? wd[4:0] : 5'h00;
    @(posedge clk_i);
    m_pend = set_v | (m_pend & ~clr_v);
    if (we && !sel) m_mask = wd;
    @(negedge clk_i);
    op_valid_i = 1'b0; src_set_i = 4'h0; host_we_i = 1'b0;
    check(tag);
  endtask

  initial begin
    #(CLK_T * 100000);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk_i);
    check("R8 during reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R8 after reset");

    step(1, 8'hA2, 0, 0, 0, 0, "R1 masked raise");
    step(0, 8'h00, 0, 1, 0, 8'h5A, "R10 mask load");
    step(0, 8'h00, 0, 1, 0, 8'h10, "R10 mask bit4 only");
    step(1, 8'hA3, 0, 0, 0, 0, "R11 other opcode");
    step(0, 8'hA2, 0, 0, 0, 0, "R11 no strobe");
    step(1, 8'hA2, 0, 0, 0, 0, "R2 enabled raise");
    step(0, 8'h00, 0, 1, 1, 8'hE0, "R6 high bits ignored");
    step(0, 8'h00, 0, 1, 1, 8'h00, "R6 zero write");
    step(0, 8'h00, 0, 1, 1, 8'h10, "R3 ack bit4");
    step(0, 8'h00, 0, 0, 0, 0, "R5 line released");
    step(1, 8'hA2, 0, 1, 1, 8'h10, "R7 raise beats ack");
    step(0, 8'h00, 4'h3, 0, 0, 0, "R9 sources unmasked");
    step(0, 8'h00, 0, 1, 0, 8'h01, "R4 summary follows mask");
    step(0, 8'h00, 4'h2, 1, 1, 8'h12, "R9 source beats ack");
    step(0, 8'h00, 0, 1, 1, 8'h01, "R4 summary self clears");
    step(0, 8'h00, 0, 1, 1, 8'h1F, "R3 clear all");

    for (int i = 0; i < 2000; i++) begin
      logic v, we, sel;
      logic [7:0] op, wd;
      logic [3:0] src;
      v   = ($urandom % 2) == 0;
      op  = ($urandom % 4) == 0 ? 8'hA2 : 8'($urandom);
      src = ($urandom % 4) == 0 ? 4'($urandom) : 4'h0;
      we  = ($urandom % 3) == 0;
      sel = ($urandom % 4) != 0;
      wd  = 8'($urandom);
      step(v, op, src, we, sel, wd, "R4 random");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule